// File: doc/BRIEF.md
# Rate-Constrained Motion Cost Unit

This unit scores one candidate motion vector for a block during motion search. It takes the motion vectors of three neighbouring blocks that are already coded and forms a predictor from them by a median taken separately on each component. It then estimates how many bits the vector difference (candidate minus predictor) would cost to code, using signed Exp-Golomb codeword lengths. That bit count is weighted by a Lagrangian multiplier, which depends on the quantizer and is supplied by the caller, and added to a plain SAD distortion value supplied from outside. The result is the combined cost of the candidate.

Because the predictor comes from the neighbours, candidates of adjacent blocks are not scored independently. The caller must present final neighbour vectors. A search engine feeds candidates one per transfer on a valid/ready input and takes the costs from a valid/ready output. The unit has a single output register. An input is accepted whenever that register is empty or is being drained in the same cycle. A result that is not taken is held unchanged until `out_ready` is high.

Top module: `mv_cost_unit`

## Requirements
- R1: The predictor is the median of the three neighbour vectors, taken separately for x and for y, with every component read as signed two's complement.
- R2: For each component, the difference d = candidate − predictor is mapped to k = 2d−1 when d > 0 and to k = −2d otherwise. Its rate is 2·floor(log2(k+1))+1 bits. The rate of the vector is the x rate plus the y rate.
- R3: The cost is sad + lambda × rate. Lambda is an unsigned 8-bit value, and the product is formed at full width.
- R4: When the sum exceeds 2^COST_W−1, the output is 2^COST_W−1.
- R5: An input accepted at a clock edge (in_valid and in_ready both high) appears on out_cost with out_valid high after that same edge. The latency is one cycle.
- R6: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid stays high and out_cost stays unchanged.
- R7: While reset is asserted, out_valid is low.
- R8: A candidate equal to the predictor has a rate of 2 bits, so its cost is sad + 2·lambda.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A candidate and its context are present |
| in_ready | output | 1 | The unit accepts the present input this cycle |
| nbr_a_x | input | MV_W | Neighbour A vector, x component, signed |
| nbr_a_y | input | MV_W | Neighbour A vector, y component, signed |
| nbr_b_x | input | MV_W | Neighbour B vector, x component, signed |
| nbr_b_y | input | MV_W | Neighbour B vector, y component, signed |
| nbr_c_x | input | MV_W | Neighbour C vector, x component, signed |
| nbr_c_y | input | MV_W | Neighbour C vector, y component, signed |
| cand_x | input | MV_W | Candidate vector, x component, signed |
| cand_y | input | MV_W | Candidate vector, y component, signed |
| sad | input | SAD_W | Distortion of the candidate, unsigned |
| lambda | input | LAM_W | Lagrangian weight, unsigned |
| out_valid | output | 1 | A cost is present |
| out_ready | input | 1 | The consumer takes the cost this cycle |
| out_cost | output | COST_W | Combined cost, saturated |

## Verification
The bench builds the unit with MV_W=8, SAD_W=12 and COST_W=12, and LAM_W left at 8. With these values the widest differences (±255, 17-bit codewords) can be driven directly. The same values make saturation reachable with a large SAD or a large lambda times rate. Directed cases cover the neighbour orderings, negative components, zero differences and the saturation edge. The rest of the run is pseudo-random traffic with an out_ready pattern that stalls the output, so the hold and accept-while-draining behaviour is exercised on every clock.

// File: rtl/mvc_pkg.sv
package mvc_pkg;
  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold the longest codeword of a DW-bit signed difference
  function automatic int len_width(input int dw);
    return $clog2(2 * dw + 2);
  endfunction
endpackage

// File: rtl/mvc_median3.sv
module mvc_median3 #(
  parameter int W = 10
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic signed [W-1:0] c,
  output logic signed [W-1:0] m
);
  logic signed [W-1:0] lo_ab, hi_ab, lo_hc;

  always_comb begin
    lo_ab = (a < b) ? a : b;
    hi_ab = (a < b) ? b : a;
    lo_hc = (hi_ab < c) ? hi_ab : c;
    m     = (lo_ab > lo_hc) ? lo_ab : lo_hc;
  end
endmodule

// File: rtl/mvc_eg_len.sv
module mvc_eg_len #(
  parameter int DW = 11,
  parameter int LW = 5
) (
  input  logic signed [DW-1:0] diff,
  output logic [LW-1:0]        len
);
  localparam int KW = DW + 1;

  logic [KW-1:0] mag, k, kp1;
  logic          neg, pos;
  int            msb;

  always_comb begin
    neg = diff[DW-1];
    pos = !neg && (diff != '0);
    mag = neg ? {1'b0, (~diff + 1'b1)} : {1'b0, diff};
    k   = {mag[KW-2:0], 1'b0} - {{(KW-1){1'b0}}, pos};
    kp1 = k + 1'b1;
    msb = 0;
    for (int i = 0; i < KW; i++) begin
      if (kp1[i]) msb = i;
    end
    len = LW'(2 * msb + 1);
  end
endmodule

// File: rtl/mv_cost_unit.sv
module mv_cost_unit
  import mvc_pkg::*;
#(
  parameter int MV_W   = 10,
  parameter int SAD_W  = 14,
  parameter int LAM_W  = 8,
  parameter int COST_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [MV_W-1:0]   nbr_a_x,
  input  logic signed [MV_W-1:0]   nbr_a_y,
  input  logic signed [MV_W-1:0]   nbr_b_x,
  input  logic signed [MV_W-1:0]   nbr_b_y,
  input  logic signed [MV_W-1:0]   nbr_c_x,
  input  logic signed [MV_W-1:0]   nbr_c_y,
  input  logic signed [MV_W-1:0]   cand_x,
  input  logic signed [MV_W-1:0]   cand_y,
  input  logic [SAD_W-1:0]         sad,
  input  logic [LAM_W-1:0]         lambda,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [COST_W-1:0]        out_cost
);
  localparam int DW = MV_W + 1;
  localparam int LW = len_width(DW);
  localparam int RW = LW + 1;
  localparam int PW = LAM_W + RW;
  localparam int SW = maxi(maxi(SAD_W, PW) + 1, COST_W + 1);

  logic signed [MV_W-1:0] med_x, med_y;
  logic signed [DW-1:0]   dx, dy;
  logic [LW-1:0]          len_x, len_y;
  logic [RW-1:0]          rate;
  logic [PW-1:0]          prod;
  logic [SW-1:0]          total;
  logic [COST_W-1:0]      cost_c;
  logic                   take;

  mvc_median3 #(.W(MV_W)) u_med_x (.a(nbr_a_x), .b(nbr_b_x), .c(nbr_c_x), .m(med_x));
  mvc_median3 #(.W(MV_W)) u_med_y (.a(nbr_a_y), .b(nbr_b_y), .c(nbr_c_y), .m(med_y));

  always_comb begin
    dx = {cand_x[MV_W-1], cand_x} - {med_x[MV_W-1], med_x};
    dy = {cand_y[MV_W-1], cand_y} - {med_y[MV_W-1], med_y};
  end

  mvc_eg_len #(.DW(DW), .LW(LW)) u_len_x (.diff(dx), .len(len_x));
  mvc_eg_len #(.DW(DW), .LW(LW)) u_len_y (.diff(dy), .len(len_y));

  always_comb begin
    rate   = {1'b0, len_x} + {1'b0, len_y};
    prod   = PW'(lambda) * PW'(rate);
    total  = SW'(sad) + SW'(prod);
    cost_c = (total > SW'({COST_W{1'b1}})) ? {COST_W{1'b1}} : total[COST_W-1:0];
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cost  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_cost  <= cost_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R1: the median agrees with at least two neighbours on each side
  p_med_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((2'(med_x >= nbr_a_x) + 2'(med_x >= nbr_b_x) + 2'(med_x >= nbr_c_x)) >= 2'd2) &&
                 ((2'(med_x <= nbr_a_x) + 2'(med_x <= nbr_b_x) + 2'(med_x <= nbr_c_x)) >= 2'd2));

  // R2: every signed Exp-Golomb codeword has odd length
  p_len_odd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (len_x[0] && len_y[0]));

  // R5: an accepted input yields a valid output on the next cycle
  p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6: a stalled result is held
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cost)));
endmodule

// File: tb/mv_cost_unit_test.sv
module mv_cost_unit_test;
  localparam int MV_W = 8, SAD_W = 12, LAM_W = 8, COST_W = 12;
  localparam int CMAX = (1 << COST_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic signed [MV_W-1:0] ax = '0, ay = '0, bx = '0, by = '0, cx = '0, cy = '0, qx = '0, qy = '0;
  logic [SAD_W-1:0] sad = '0;
  logic [LAM_W-1:0] lam = '0;
  logic [COST_W-1:0] out_cost;

  always #2 clk = ~clk;

  mv_cost_unit #(.MV_W(MV_W), .SAD_W(SAD_W), .LAM_W(LAM_W), .COST_W(COST_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .nbr_a_x(ax), .nbr_a_y(ay), .nbr_b_x(bx), .nbr_b_y(by),
    .nbr_c_x(cx), .nbr_c_y(cy), .cand_x(qx), .cand_y(qy),
    .sad(sad), .lambda(lam), .out_valid(out_valid), .out_ready(out_ready),
    .out_cost(out_cost));

  int total = 0, bad = 0;
  bit m_valid = 0;
  int m_cost = 0;
  string m_tag = "R5";
  string cur_tag = "R3";

  function automatic int med3(int a, int b, int c);
    int lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    if (c <= lo) return lo;
    if (c >= hi) return hi;
    return c;
  endfunction

  function automatic int eglen(int d);
    int k, n;
    k = (d > 0) ? 2 * d - 1 : -2 * d;
    n = 0;
    while (((k + 1) >> (n + 1)) != 0) n++;
    return 2 * n + 1;
  endfunction

  function automatic int ref_cost();
    int px, py, r, s;
    px = med3(int'(ax), int'(bx), int'(cx));
    py = med3(int'(ay), int'(by), int'(cy));
    r  = eglen(int'(qx) - px) + eglen(int'(qy) - py);
    s  = int'(sad) + int'(lam) * r;
    return (s > CMAX) ? CMAX : s;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // model step at each falling edge: apply the rising edge just passed
  task automatic step(bit v, bit rdy, int a_x, int a_y, int b_x, int b_y,
                      int c_x, int c_y, int q_x, int q_y, int s, int l, string tag);
    bit m_ready, held;
    m_ready = !m_valid || out_ready;
    held = m_valid && !out_ready;
    @(posedge clk);
    if (in_valid && m_ready) begin
      m_valid = 1;
      m_cost  = ref_cost();
      m_tag   = cur_tag;
    end else if (out_ready) begin
      m_valid = 0;
    end else if (held) begin
      m_tag = "R6";
    end
    @(negedge clk);
    check("R5", int'(out_valid), int'(m_valid));
    if (m_valid) check(m_tag, int'(out_cost), m_cost);
    in_valid = v; out_ready = rdy;
    ax = a_x[MV_W-1:0]; ay = a_y[MV_W-1:0]; bx = b_x[MV_W-1:0]; by = b_y[MV_W-1:0];
    cx = c_x[MV_W-1:0]; cy = c_y[MV_W-1:0]; qx = q_x[MV_W-1:0]; qy = q_y[MV_W-1:0];
    sad = s[SAD_W-1:0]; lam = l[LAM_W-1:0]; cur_tag = tag;
    #1;
    check("R6", int'(in_ready), int'(!m_valid || out_ready));
  endtask

  initial begin
    int cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", int'(out_valid), 0);
    // R1 orderings, R2 lengths, lambda 1 so cost shows rate
    step(1, 1,  3, -5,  7,  2, -1,  9,   0, 0,  0, 1, "R1");
    step(1, 1, -8, 4, -2, -20, -5, 6,  -5, 4,  0, 1, "R1");
    step(1, 1, 10, 10, 10, -3, 1, 10,  12, 9,  0, 1, "R1");
    step(1, 1, 0, 0, 0, 0, 0, 0,   1, -1,  0, 1, "R2");
    step(1, 1, 0, 0, 0, 0, 0, 0,   2, -2,  0, 1, "R2");
    step(1, 1, -128, -128, -128, -128, -128, -128, 127, 127, 0, 1, "R2");
    step(1, 1, 127, 127, 127, 127, 127, 127, -128, -128, 0, 1, "R2");
    // R8 zero difference
    step(1, 1, 4, -4, 6, -6, 5, -5,  5, -5,  5, 10, "R8");
    // R3 weighted sum
    step(1, 1, 1, 2, 3, 4, 5, 6,  -7, 9,  100, 13, "R3");
    // R4 saturation edge and beyond
    step(1, 1, 0, 0, 0, 0, 0, 0,  0, 0,  4093, 1, "R4");
    step(1, 1, 0, 0, 0, 0, 0, 0,  0, 0,  4094, 1, "R4");
    step(1, 1, -128, 0, -128, 0, -128, 0,  127, 0,  4000, 255, "R4");
    // R6 stall: hold output, then drain while accepting
    step(1, 0, 2, 2, 2, 2, 2, 2,  9, 9,  50, 3, "R6");
    step(1, 0, 1, 1, 1, 1, 1, 1,  3, 3,  70, 2, "R6");
    step(1, 0, 1, 1, 1, 1, 1, 1,  3, 3,  70, 2, "R6");
    step(1, 1, 1, 1, 1, 1, 1, 1,  3, 3,  70, 2, "R6");
    step(0, 1, 0, 0, 0, 0, 0, 0,  0, 0,  0, 0, "R5");
    step(0, 1, 0, 0, 0, 0, 0, 0,  0, 0,  0, 0, "R5");
    // random traffic with back-pressure
    for (int i = 0; i < 400; i++) begin
      step(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 2) != 0),
           $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
           $urandom_range(0, 4095), $urandom_range(0, 255), "R3");
    end
    step(0, 1, 0, 0, 0, 0, 0, 0,  0, 0,  0, 0, "R5");
    step(0, 1, 0, 0, 0, 0, 0, 0,  0, 0,  0, 0, "R5");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule